// File: doc/BRIEF.md
# Analog Monitor Fault and PWM Reporter

This block watches two digitized analog monitor channels. Each channel has its own programmable threshold and its own comparison sense: it either trips when the sample is above the threshold or when it is below it. A trip is latched as a fault. The fault stays set until the host asserts the clear input. Each fault has a mask bit. Any latched fault whose mask bit is clear pulls two active-low fault indicators low. Each indicator is modelled as an open-drain pin, so a released pin reads as 1.

The second indicator can be switched into a push-pull data mode. In that mode it carries a PWM waveform with a period of 2^CODE_W clocks. Its high time equals the most recent code of a selected channel. Codes span 0 to 4.0 V full scale: code 0 is 0 V and the largest code is 4.0 V. A new duty value is taken only at a period boundary. After the mode is entered, the pin stays released until the next period boundary. Three register write ports load the settings. The ADC, the analog front end and the serial transport sit outside the block. Samples arrive as a code, a channel number and a valid strobe.

Each channel runs a two-state machine. CH_WATCH moves to CH_TRIPPED on "trip", which is a valid sample beyond the threshold with no clear in the same cycle. CH_TRIPPED returns to CH_WATCH on "release", which is the clear input.

The second pin runs a three-state machine:
- P2_IRQ is fault-indicator mode.
- P2_IRQ moves to P2_ALIGN on "arm", when the mode bit is set.
- P2_ALIGN moves to P2_PWM on "lock", at the last count of the PWM period.
- P2_ALIGN and P2_PWM both return to P2_IRQ on "drop", when the mode bit is cleared.

Top module: `amon_fault_reporter`

## Requirements
- R1: After reset both indicators read 1, no fault is latched, every register is 0 and the second pin is in fault-indicator mode.
- R2: Register map (address: content). Address 0 is the channel 0 threshold and address 1 is the channel 1 threshold. Address 2 is control:
  - bits [1:0]: sense of channel 0 and channel 1 (1 = trip when code > threshold, 0 = trip when code < threshold);
  - bits [3:2]: masks of channel 0 and channel 1 (1 = masked);
  - bit 4: second-pin PWM mode;
  - bit 5: PWM source channel.

  Writes to address 3 are ignored.
- R3: With sense 1, a valid sample with code strictly above the threshold latches the fault on the clock edge that samples it. A code equal to or below the threshold does not.
- R4: With sense 0, a valid sample with code strictly below the threshold latches the fault. A code equal to or above the threshold does not.
- R5: A latched fault stays set after later in-limit samples until fault_clr is asserted.
- R6: fault_clr clears all faults on the next edge and wins over a tripping sample in the same cycle.
- R7: In fault-indicator mode, both indicators are 0 while any unmasked fault is latched and 1 otherwise.
- R8: A masked fault holds neither indicator low but stays latched. Clearing its mask bit pulls the indicators low.
- R9: In PWM mode the second pin is high for exactly `code` clocks of every 2^CODE_W-clock period, where code is the latest sample of the selected channel. The first indicator keeps reporting faults, and faults do not affect the second pin.
- R10: Code 0 gives a pin that is always low. The maximum code (1023 by default) gives 1023 high clocks per 1024-clock period.
- R11: A new code arriving mid-period does not change the current period's high time; it applies from the next period.
- R12: The PWM source bit selects which channel's latest code sets the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | CODE_W | Register write data |
| samp_valid | input | 1 | Sample strobe |
| samp_ch | input | 1 | Channel number of the sample |
| samp_code | input | CODE_W | Sample code |
| fault_clr | input | 1 | Clears all latched faults |
| flt1_n | output | 1 | First fault indicator, active low, 1 = released |
| flt2_dout | output | 1 | Second fault indicator or PWM data output |

## Verification
The comparators are driven with codes one below, equal to and one above the threshold, in both senses. This separates strict from inclusive comparison and an inverted sense bit. Thresholds of 0 and the maximum code expose wrap or sign errors. The latch and mask behaviour is tried in three ways: an in-limit sample after a trip, a clear together with a tripping sample, and unmasking an already latched fault. These tell a level-sensitive or mask-gated latch from the intended one. The PWM high time is counted over whole periods for codes 0, 300, 555, 800 and 1023 on both source channels. A code change injected 100 clocks into a period shows whether the duty is reloaded mid-period.

// File: rtl/amfr_pkg.sv
package amfr_pkg;

    localparam int NCH = 2;

    typedef enum logic {
        CH_WATCH   = 1'b0,
        CH_TRIPPED = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        P2_IRQ   = 2'd0,
        P2_ALIGN = 2'd1,
        P2_PWM   = 2'd2
    } p2_state_e;

    typedef struct packed {
        logic           pwm_src;
        logic           pwm_mode;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] above;
    } ctrl_t;

endpackage

// File: rtl/amfr_cfg_regs.sv
module amfr_cfg_regs
    import amfr_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] thr [NCH],
    output ctrl_t             ctrl
);

    localparam int CTRL_W = $bits(ctrl_t);

    for (genvar i = 0; i < NCH; i++) begin : g_thr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr[i] <= '0;
            end else if (we && addr == 2'(i)) begin
                thr[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we && addr == 2'd2) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

endmodule

// File: rtl/amfr_chan_cmp.sv
module amfr_chan_cmp
    import amfr_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thr,
    input  logic              above,
    input  logic              clr,
    output logic              fault,
    output logic [CODE_W-1:0] last_code
);

    ch_state_e state_q, state_d;
    logic      beyond;

    always_comb begin
        beyond = above ? (code > thr) : (code < thr);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_WATCH:   if (valid && beyond && !clr) state_d = CH_TRIPPED;
            CH_TRIPPED: if (clr)                     state_d = CH_WATCH;
            default:                                 state_d = CH_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_code <= '0;
        end else if (valid) begin
            last_code <= code;
        end
    end

    always_comb begin
        fault = (state_q == CH_TRIPPED);
    end

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr) |=> fault); // R5
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fault); // R6
    AST_QUIET_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !valid) |=> !fault); // R3

endmodule

// File: rtl/amfr_pwm_gen.sv
module amfr_pwm_gen
    import amfr_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req,
    input  logic [CODE_W-1:0] duty_src,
    output p2_state_e         state,
    output logic              level
);

    localparam logic [CODE_W-1:0] LAST = {CODE_W{1'b1}};

    p2_state_e         state_q, state_d;
    logic [CODE_W-1:0] cnt_q;
    logic [CODE_W-1:0] duty_q;
    logic              wrap;

    always_comb begin
        wrap = (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (wrap) begin
                duty_q <= duty_src;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P2_IRQ:   if (mode_req)  state_d = P2_ALIGN;
            P2_ALIGN: if (!mode_req) state_d = P2_IRQ;
                      else if (wrap) state_d = P2_PWM;
            P2_PWM:   if (!mode_req) state_d = P2_IRQ;
            default:                 state_d = P2_IRQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P2_IRQ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state = state_q;
        level = (cnt_q < duty_q);
    end

    AST_DUTY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(duty_q)); // R11
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !level); // R10
    AST_PWM_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P2_ALIGN && state_d == P2_PWM) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/amon_fault_reporter.sv
module amon_fault_reporter
    import amfr_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CODE_W-1:0] cfg_wdata,
    input  logic              samp_valid,
    input  logic              samp_ch,
    input  logic [CODE_W-1:0] samp_code,
    input  logic              fault_clr,
    output logic              flt1_n,
    output logic              flt2_dout
);

    logic [CODE_W-1:0] thr [NCH];
    ctrl_t             ctrl;
    logic [NCH-1:0]    fault;
    logic [CODE_W-1:0] last_code [NCH];
    logic [CODE_W-1:0] duty_src;
    p2_state_e         p2_state;
    logic              pwm_level;
    logic              any_live;

    amfr_cfg_regs #(.CODE_W(CODE_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .thr   (thr),
        .ctrl  (ctrl)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        amfr_chan_cmp #(.CODE_W(CODE_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid     (samp_valid && (samp_ch == 1'(i))),
            .code      (samp_code),
            .thr       (thr[i]),
            .above     (ctrl.above[i]),
            .clr       (fault_clr),
            .fault     (fault[i]),
            .last_code (last_code[i])
        );
    end

    always_comb begin
        duty_src = last_code[ctrl.pwm_src];
        any_live = |(fault & ~ctrl.mask);
    end

    amfr_pwm_gen #(.CODE_W(CODE_W)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (ctrl.pwm_mode),
        .duty_src (duty_src),
        .state    (p2_state),
        .level    (pwm_level)
    );

    always_comb begin
        flt1_n = !any_live;
        unique case (p2_state)
            P2_IRQ:   flt2_dout = !any_live;
            P2_ALIGN: flt2_dout = 1'b1;
            P2_PWM:   flt2_dout = pwm_level;
            default:  flt2_dout = 1'b1;
        endcase
    end

    AST_PIN1_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault & ~ctrl.mask)) |-> !flt1_n); // R7
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault & ~ctrl.mask) == '0) |-> flt1_n); // R8
    AST_PIN2_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_state == P2_IRQ) |-> (flt2_dout == flt1_n)); // R7

endmodule

// File: tb/amon_fault_reporter_bench.sv
`timescale 1ns/1ps
module amon_fault_reporter_bench;

    localparam int CODE_W = 10;
    localparam int PER    = 1 << CODE_W;

    // row: {ch, above, thr[9:0], code[9:0], expected indicator}
    localparam logic [22:0] VEC [8] = '{
        {1'b0, 1'b1, 10'd500,  10'd501,  1'b0},
        {1'b0, 1'b1, 10'd500,  10'd500,  1'b1},
        {1'b0, 1'b1, 10'd500,  10'd499,  1'b1},
        {1'b0, 1'b0, 10'd500,  10'd499,  1'b0},
        {1'b0, 1'b0, 10'd500,  10'd500,  1'b1},
        {1'b1, 1'b1, 10'd0,    10'd1,    1'b0},
        {1'b1, 1'b0, 10'd1023, 10'd1022, 1'b0},
        {1'b1, 1'b1, 10'd1023, 10'd1023, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [CODE_W-1:0] cfg_wdata = '0;
    logic              samp_valid = 1'b0;
    logic              samp_ch = 1'b0;
    logic [CODE_W-1:0] samp_code = '0;
    logic              fault_clr = 1'b0;
    logic              flt1_n;
    logic              flt2_dout;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    amon_fault_reporter #(.CODE_W(CODE_W)) u_amon_fault_reporter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .samp_valid(samp_valid), .samp_ch(samp_ch),
        .samp_code(samp_code), .fault_clr(fault_clr),
        .flt1_n(flt1_n), .flt2_dout(flt2_dout)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CODE_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic smp(input logic ch, input logic [CODE_W-1:0] c, input logic clr);
        @(negedge clk);
        samp_valid = 1'b1; samp_ch = ch; samp_code = c; fault_clr = clr;
        @(negedge clk);
        samp_valid = 1'b0; fault_clr = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    task automatic high_count(output int hi);
        hi = 0;
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            if (flt2_dout) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flt1", flt1_n, 1);
        chk("R1 flt2", flt2_dout, 1);
        rst_n = 1'b1;
        @(negedge clk);
        smp(1'b0, 10'd5, 1'b0);   // threshold 0, sense below: no trip
        chk("R1 regs zero", flt1_n, 1);

        // table: R3 R4 R7, map per R2
        for (int r = 0; r < 8; r++) begin
            logic [22:0] v;
            v = VEC[r];
            clear_all();
            wr({1'b0, v[22]}, v[20:11]);
            wr(2'd2, {4'd0, 6'b00_00_00} | {8'd0, v[21], v[21]});
            smp(v[22], v[10:1], 1'b0);
            chk($sformatf("R3/R4 row%0d flt1", r), flt1_n, v[0]);
            chk($sformatf("R7 row%0d flt2", r), flt2_dout, v[0]);
        end

        // R5 latch holds
        clear_all();
        wr(2'd0, 10'd200);
        wr(2'd2, 10'b00_0011);
        smp(1'b0, 10'd300, 1'b0);
        smp(1'b0, 10'd100, 1'b0);
        chk("R5 held after in-limit", flt1_n, 0);
        clear_all();
        chk("R5 cleared", flt1_n, 1);

        // R6 clear wins
        smp(1'b0, 10'd300, 1'b1);
        chk("R6 clear beats trip", flt1_n, 1);

        // R8 mask
        wr(2'd2, 10'b00_0111);
        smp(1'b0, 10'd300, 1'b0);
        chk("R8 masked flt1", flt1_n, 1);
        chk("R8 masked flt2", flt2_dout, 1);
        wr(2'd2, 10'b00_0011);
        chk("R8 unmask latched", flt1_n, 0);

        // R2 write to address 3 ignored
        clear_all();
        wr(2'd3, 10'h3ff);
        smp(1'b0, 10'd150, 1'b0);
        chk("R2 addr3 ignored", flt1_n, 1);

        // PWM setup: ch0 never trips (above 1023), ch1 trips below 1023
        clear_all();
        wr(2'd0, 10'd1023);
        wr(2'd1, 10'd1023);
        smp(1'b1, 10'd555, 1'b0);
        clear_all();
        smp(1'b0, 10'd300, 1'b0);
        wr(2'd2, 10'b01_0001);
        repeat (2 * PER + 50) @(negedge clk);
        high_count(hi);
        chk("R9 duty 300", hi, 300);

        // R11 mid-period update: align to period start
        while (flt2_dout) @(negedge clk);
        while (!flt2_dout) @(negedge clk);
        hi = 1;
        for (int k = 1; k < PER; k++) begin
            @(negedge clk);
            if (flt2_dout) hi++;
            if (k == 100) begin samp_valid = 1'b1; samp_ch = 1'b0; samp_code = 10'd800; end
            if (k == 101) samp_valid = 1'b0;
        end
        chk("R11 old duty kept", hi, 300);
        high_count(hi);
        chk("R11 new duty next period", hi, 800);

        // R12 source select, R9 faults on pin1 only
        wr(2'd2, 10'b11_0001);
        repeat (PER + 50) @(negedge clk);
        high_count(hi);
        chk("R12 ch1 source", hi, 555);
        smp(1'b1, 10'd555, 1'b0);
        chk("R9 flt1 in pwm mode", flt1_n, 0);
        repeat (PER) @(negedge clk);
        high_count(hi);
        chk("R9 pin2 ignores fault", hi, 555);

        // R10 extremes
        clear_all();
        wr(2'd2, 10'b01_0001);
        smp(1'b0, 10'd0, 1'b0);
        repeat (PER + 50) @(negedge clk);
        high_count(hi);
        chk("R10 code 0", hi, 0);
        smp(1'b0, 10'd1023, 1'b0);
        repeat (PER + 50) @(negedge clk);
        high_count(hi);
        chk("R10 code max", hi, 1023);

        // R1 mode drop returns to indicator
        wr(2'd2, 10'b00_0001);
        repeat (4) @(negedge clk);
        chk("R7 back to indicator", flt2_dout, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule